// File: doc/BRIEF.md
# Interrupt Controller Shadow Readback Port

This block watches I/O writes on their way to a cascaded pair of legacy programmable interrupt controllers. It keeps a copy of each controller's initialization command words (ICW1 to ICW4) and of the two operation command words that cannot be read back from the controllers themselves (OCW2 and OCW3). Power-management or context-save code reads all twelve copies through a single 8-bit read-only port. Every read of the port moves on to the next copy.

The controllers accept their initialization words as a sequence. ICW1 goes to the even address. ICW2, ICW3 and ICW4 then follow on the odd address, and ICW1 decides which of them are expected. So each controller has its own sequence tracker in the block, which tells which command word an odd-address write carries. Odd-address writes that fall outside an initialization sequence are interrupt mask writes and are not recorded. A write strobe on the shadow port rewinds its read pointer to the first entry.

Top module: `pic_shadow_port`

## Requirements
- R1: After reset every entry holds 00h, the read pointer selects entry 0, and the read byte is 00h.
- R2: Writes to 20h/21h are taken as primary controller accesses and writes to A0h/A1h as secondary ones. A write to any other address changes no entry.
- R3: An even-address write with bit 4 set is stored as ICW1 and restarts that controller's initialization sequence, even in the middle of an earlier one.
- R4: The first odd-address write after ICW1 is stored as ICW2.
- R5: The next odd-address write is stored as ICW3 only when ICW1 bit 1 (single mode) is clear. Otherwise ICW3 keeps its old value.
- R6: A further odd-address write is stored as ICW4 only when ICW1 bit 0 is set. Bits 7:5 of a stored ICW4 read as 0.
- R7: Odd-address writes after the sequence has ended (mask writes) change no entry.
- R8: An even-address write with bits 4:3 = 00 is stored as OCW2 with bits 6:3 forced to 0. A restore written as the value v followed by v|C0h leaves the entry at (v|C0h) with bits 6:3 cleared.
- R9: An even-address write with bits 4:3 = 01 is stored as OCW3, unchanged.
- R10: Entries 0 to 5 are primary ICW1, ICW2, ICW3, ICW4, OCW2, OCW3, and entries 6 to 11 are the same words for the secondary controller. The read byte always shows the entry that the pointer selects.
- R11: Each read strobe advances the pointer by one entry, and it wraps from entry 11 to entry 0.
- R12: A shadow-port write strobe sets the pointer to entry 0. It takes priority over a read strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Snooped I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W (16) | Snooped I/O write address |
| io_wdata | input | 8 | Snooped I/O write data |
| shd_rd | input | 1 | Shadow port read strobe; advances the pointer after this cycle |
| shd_wr | input | 1 | Shadow port write strobe; rewinds the pointer |
| shd_rdata | output | 8 | Entry selected by the pointer |

## Verification
The assertions assume that each I/O write lasts exactly one cycle. They also assume that software starts each controller with ICW1 before it relies on the odd-address entries, so a tracker never expects ICW3 in single mode or ICW4 without the ICW4 flag. The bench drives single-cycle strobes at the falling edge and begins every initialization with an ICW1. Its sequences cover a single-mode init, a cascade init, an ICW1 sent in the middle of a sequence, mask writes after completion, and writes to foreign addresses. The read strobe is driven alone and also together with the write strobe.

// File: rtl/pic_shadow_pkg.sv
package pic_shadow_pkg;

   localparam int NUM_CTRL       = 2;
   localparam int WORDS_PER_CTRL = 6;
   localparam int NUM_ENTRIES    = NUM_CTRL * WORDS_PER_CTRL;
   localparam int PTR_W          = $clog2(NUM_ENTRIES);
   localparam int BYTE_W         = 8;

   // slot of each word inside one controller's group; order is the read order
   localparam int SLOT_ICW1 = 0;
   localparam int SLOT_ICW2 = 1;
   localparam int SLOT_ICW3 = 2;
   localparam int SLOT_ICW4 = 3;
   localparam int SLOT_OCW2 = 4;
   localparam int SLOT_OCW3 = 5;

   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WANT_ICW2 = 2'd1,
      ST_WANT_ICW3 = 2'd2,
      ST_WANT_ICW4 = 2'd3
   } init_state_e;

   typedef logic [WORDS_PER_CTRL-1:0][BYTE_W-1:0] ctrl_words_t;

endpackage

// File: rtl/pic_port_match.sv
module pic_port_match #(
   parameter int               ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE  = '0
) (
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              hit,
   output logic              odd
);

   if (BASE[0] != 1'b0) begin : g_bad_base
      $error("pic_port_match: BASE must be even");
   end

   assign hit = io_wr && (io_addr[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
   assign odd = io_addr[0];

endmodule

// File: rtl/pic_init_tracker.sv
module pic_init_tracker
   import pic_shadow_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RESET_WORD = 8'h00,
   parameter logic [BYTE_W-1:0] ICW4_KEEP  = 8'h1F,
   parameter logic [BYTE_W-1:0] OCW2_KEEP  = 8'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              odd,
   input  logic [BYTE_W-1:0] wdata,
   output ctrl_words_t       words_o
);

   init_state_e state;
   logic        single_q;
   logic        need4_q;
   ctrl_words_t words;

   logic is_icw1, is_ocw2, is_ocw3;
   assign is_icw1 = hit && !odd && wdata[4];
   assign is_ocw2 = hit && !odd && (wdata[4:3] == 2'b00);
   assign is_ocw3 = hit && !odd && (wdata[4:3] == 2'b01);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words    <= {WORDS_PER_CTRL{RESET_WORD}};
         state    <= ST_IDLE;
         single_q <= 1'b0;
         need4_q  <= 1'b0;
      end else if (is_icw1) begin
         words[SLOT_ICW1] <= wdata;
         state            <= ST_WANT_ICW2;
         single_q         <= wdata[1];
         need4_q          <= wdata[0];
      end else if (is_ocw2) begin
         words[SLOT_OCW2] <= wdata & OCW2_KEEP;
      end else if (is_ocw3) begin
         words[SLOT_OCW3] <= wdata;
      end else if (hit && odd) begin
         unique case (state)
            ST_WANT_ICW2: begin
               words[SLOT_ICW2] <= wdata;
               if (!single_q)    state <= ST_WANT_ICW3;
               else if (need4_q) state <= ST_WANT_ICW4;
               else              state <= ST_IDLE;
            end
            ST_WANT_ICW3: begin
               words[SLOT_ICW3] <= wdata;
               state            <= need4_q ? ST_WANT_ICW4 : ST_IDLE;
            end
            ST_WANT_ICW4: begin
               words[SLOT_ICW4] <= wdata & ICW4_KEEP;
               state            <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign words_o = words;

   AST_ICW1_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      is_icw1 |=> (state == ST_WANT_ICW2)); // R3
   AST_ICW2_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && odd && state == ST_WANT_ICW2) |=> (words[SLOT_ICW2] == $past(wdata))); // R4
   AST_ICW3_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WANT_ICW3) |-> !single_q); // R5
   AST_ICW4_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WANT_ICW4) |-> need4_q); // R6
   AST_MASK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && odd && state == ST_IDLE) |=> $stable(words)); // R7

endmodule

// File: rtl/shadow_read_ptr.sv
module shadow_read_ptr #(
   parameter int N     = 12,
   parameter int PTR_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             rewind,
   output logic [PTR_W-1:0] ptr_o
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

   if (N < 2) begin : g_bad_n
      $error("shadow_read_ptr: N must be at least 2");
   end

   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (!rst_n)          ptr <= '0;
      else if (rewind)     ptr <= '0;
      else if (step)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   assign ptr_o = ptr;

   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST); // R11
   AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rewind && ptr == LAST) |=> (ptr == '0)); // R11
   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rewind && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R11
   AST_REWIND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> (ptr == '0)); // R12

endmodule

// File: rtl/pic_shadow_port.sv
module pic_shadow_port
   import pic_shadow_pkg::*;
#(
   parameter int               ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] PRI_BASE  = 'h20,
   parameter logic [ADDR_W-1:0] SEC_BASE  = 'hA0,
   parameter logic [7:0]        RESET_WORD = 8'h00,
   parameter logic [7:0]        ICW4_KEEP  = 8'h1F,
   parameter logic [7:0]        OCW2_KEEP  = 8'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              shd_rd,
   input  logic              shd_wr,
   output logic [7:0]        shd_rdata
);

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("pic_shadow_port: ADDR_W too small");
   end
   if (PRI_BASE[ADDR_W-1:1] == SEC_BASE[ADDR_W-1:1]) begin : g_bad_bases
      $error("pic_shadow_port: controller bases overlap");
   end

   logic [NUM_ENTRIES-1:0][BYTE_W-1:0] entry;
   logic [NUM_CTRL-1:0]                ctrl_hit;
   logic [PTR_W-1:0]                   ptr;

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      localparam logic [ADDR_W-1:0] BASE = (g == 0) ? PRI_BASE : SEC_BASE;
      logic        odd;
      ctrl_words_t words;

      pic_port_match #(.ADDR_W(ADDR_W), .BASE(BASE)) i_match (
         .io_wr  (io_wr),
         .io_addr(io_addr),
         .hit    (ctrl_hit[g]),
         .odd    (odd)
      );

      pic_init_tracker #(
         .RESET_WORD(RESET_WORD),
         .ICW4_KEEP (ICW4_KEEP),
         .OCW2_KEEP (OCW2_KEEP)
      ) i_tracker (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (ctrl_hit[g]),
         .odd    (odd),
         .wdata  (io_wdata),
         .words_o(words)
      );

      assign entry[g*WORDS_PER_CTRL +: WORDS_PER_CTRL] = words;
   end

   shadow_read_ptr #(.N(NUM_ENTRIES), .PTR_W(PTR_W)) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (shd_rd),
      .rewind(shd_wr),
      .ptr_o (ptr)
   );

   assign shd_rdata = entry[ptr];

   AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && ctrl_hit == '0 && !shd_rd && !shd_wr) |=> $stable(shd_rdata)); // R2
   AST_ONE_CTRL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_hit)); // R2

endmodule

// File: tb/test_pic_shadow_port.sv
`timescale 1ns/1ps
module test_pic_shadow_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        shd_rd = 1'b0;
   logic        shd_wr = 1'b0;
   logic [7:0]  shd_rdata;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   pic_shadow_port i_pic_shadow_port (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .shd_rd(shd_rd), .shd_wr(shd_wr), .shd_rdata(shd_rdata)
   );

   // behavioural reference
   byte unsigned m_word [12];
   int           m_state [2];   // 0 idle, 2/3/4 = next expected ICW number
   bit           m_single [2];
   bit           m_need4 [2];
   int           m_ptr;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_word[i]) m_word[i] = 8'h00;
         m_state = '{0, 0};
         m_ptr = 0;
      end else begin
         if (io_wr) begin
            int c;
            c = -1;
            if (io_addr == 16'h20 || io_addr == 16'h21) c = 0;
            if (io_addr == 16'hA0 || io_addr == 16'hA1) c = 1;
            if (c >= 0) begin
               if (!io_addr[0]) begin
                  if (io_wdata[4]) begin
                     m_word[c*6] = io_wdata;
                     m_state[c] = 2;
                     m_single[c] = io_wdata[1];
                     m_need4[c] = io_wdata[0];
                  end else if (!io_wdata[3]) m_word[c*6+4] = io_wdata & 8'h87;
                  else m_word[c*6+5] = io_wdata;
               end else begin
                  case (m_state[c])
                     2: begin
                        m_word[c*6+1] = io_wdata;
                        m_state[c] = !m_single[c] ? 3 : (m_need4[c] ? 4 : 0);
                     end
                     3: begin
                        m_word[c*6+2] = io_wdata;
                        m_state[c] = m_need4[c] ? 4 : 0;
                     end
                     4: begin
                        m_word[c*6+3] = io_wdata & 8'h1F;
                        m_state[c] = 0;
                     end
                     default: ;
                  endcase
               end
            end
         end
         if (shd_wr) m_ptr = 0;
         else if (shd_rd) m_ptr = (m_ptr + 1) % 12;
      end
   end

   // compare every cycle, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      checks++;
      if (shd_rdata !== m_word[m_ptr]) begin
         fails++;
         $display("FAIL %s: per-cycle read byte actual %02h expected %02h", cur_req,
                  shd_rdata, m_word[m_ptr]);
      end
   end

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rewind();
      @(negedge clk);
      shd_wr = 1'b1;
      @(negedge clk);
      shd_wr = 1'b0;
   endtask

   task automatic read_expect(input logic [7:0] exp, input string req);
      @(negedge clk);
      checks++;
      if (shd_rdata !== exp) begin
         fails++;
         $display("FAIL %s: read byte actual %02h expected %02h", req, shd_rdata, exp);
      end
      shd_rd = 1'b1;
      @(negedge clk);
      shd_rd = 1'b0;
   endtask

   initial begin
      #(4ns * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      read_expect(8'h00, "R1");
      read_expect(8'h00, "R1");
      rewind();

      // primary: cascade, ICW4 wanted
      cur_req = "R4";
      io_write(16'h20, 8'h11);
      io_write(16'h21, 8'h08);
      io_write(16'h21, 8'h04);
      io_write(16'h21, 8'hFF);   // R6: top bits dropped
      cur_req = "R7";
      io_write(16'h21, 8'hAB);   // mask write, ignored
      // secondary: single mode with ICW4 -> no ICW3
      cur_req = "R5";
      io_write(16'hA0, 8'h13);
      io_write(16'hA1, 8'h70);
      io_write(16'hA1, 8'hE3);
      io_write(16'hA1, 8'h55);   // R7 mask
      cur_req = "R2";
      io_write(16'h40, 8'h1F);
      io_write(16'h0021, 8'h99);
      io_write(16'h1020, 8'h17);
      cur_req = "R8";
      io_write(16'h20, 8'hE7);
      io_write(16'h20, 8'h05);
      io_write(16'h20, 8'hC5);   // restore pair
      io_write(16'hA0, 8'h60);
      cur_req = "R9";
      io_write(16'h20, 8'h0B);
      io_write(16'hA0, 8'h68);

      cur_req = "R10";
      rewind();
      read_expect(8'h11, "R3");
      read_expect(8'h08, "R4");
      read_expect(8'h04, "R5");
      read_expect(8'h1F, "R6");
      read_expect(8'h85, "R8");
      read_expect(8'h0B, "R9");
      read_expect(8'h13, "R10");
      read_expect(8'h70, "R4");
      read_expect(8'h00, "R5");
      read_expect(8'h03, "R6");
      read_expect(8'h00, "R8");
      read_expect(8'h68, "R9");
      cur_req = "R11";
      read_expect(8'h11, "R11");
      read_expect(8'h08, "R11");

      // rewind together with read strobe
      cur_req = "R12";
      @(negedge clk);
      shd_wr = 1'b1; shd_rd = 1'b1;
      @(negedge clk);
      shd_wr = 1'b0; shd_rd = 1'b0;
      read_expect(8'h11, "R12");

      // restart mid-sequence, then single mode without ICW4
      cur_req = "R3";
      io_write(16'h20, 8'h11);
      io_write(16'h21, 8'h20);
      io_write(16'h20, 8'h10);
      io_write(16'h21, 8'h28);
      io_write(16'h21, 8'h02);
      io_write(16'h21, 8'h77);   // sequence ended: mask
      rewind();
      read_expect(8'h10, "R3");
      read_expect(8'h28, "R3");
      read_expect(8'h02, "R3");
      read_expect(8'h1F, "R7");
      cur_req = "R5";
      io_write(16'hA0, 8'h12);
      io_write(16'hA1, 8'h90);
      io_write(16'hA1, 8'h44);   // mask, ICW3 untouched
      rewind();
      repeat (6) begin
         @(negedge clk); shd_rd = 1'b1;
         @(negedge clk); shd_rd = 1'b0;
      end
      read_expect(8'h12, "R5");
      read_expect(8'h90, "R5");
      read_expect(8'h00, "R5");
      read_expect(8'h03, "R7");

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule